// File: doc/BRIEF.md
# Square-Root-Free Symmetric Matrix Factorizer

This block splits a symmetric positive-definite 9x9 matrix B into a unit lower-triangular factor L and a diagonal factor D, so that B = L·D·Lᵀ. No square root is ever taken. The matrix is written one entry per cycle through an indexed load port into local storage. A single-cycle start pulse begins the run, and the results are written back over the storage in place. After the done pulse, L and D are read through a combinational indexed read port.

The work goes column by column. Within column j the pivot d_jj is formed first, from the diagonal entry minus the already-weighted squares of earlier entries in row j. Then each entry below the pivot is formed, from the matching entry of B minus a weighted inner product of earlier columns, divided by the new pivot. Every value used has been finished before it is needed. All arithmetic is signed Q16.16 with one rounded product at a time. A restoring divider takes 32 iterations per quotient. If a pivot is zero or negative, the run stops early and a singular flag is raised.

Top module: `ldlt_factor`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `singular` are low and all stored entries are zero. A D read returns 0, and an L read returns 0x00010000 on the diagonal and 0 elsewhere.
- R2: While idle, a load write to (row, col) with both indices below 9 stores the 32-bit value. The factorization uses only entries with row ≥ col, so values written above the diagonal have no effect on the results.
- R3: A start pulse while idle raises `busy` in the next cycle. `busy` stays high until the cycle in which `done` is high for exactly one cycle, and in that cycle `busy` is already low. A complete run takes, for each column j (from 0), j+1 cycles for the pivot plus j+34 cycles for each entry below it.
- R4: The pivot is d_jj = b_jj − Σ_{k<j} rnd(rnd(l_jk·d_kk)·l_jk). The terms are added in increasing k with 32-bit wrap. rnd(x·y) is the 64-bit product plus 2^15, arithmetically shifted right by 16, keeping the low 32 bits.
- R5: The entry below the pivot is l_ij = q(b_ij − Σ_{k<j} rnd(rnd(l_ik·d_kk)·l_jk), d_jj). Here q is the Q16.16 quotient (|n|·2^16)/|d|, truncated toward zero, with its magnitude limited to 0x7FFFFFFF and negated when the operand signs differ.
- R6: A pivot ≤ 0 at column j ends the run after the earlier columns' cycles plus j+1 cycles. `done` pulses and `singular` rises in that cycle, and the columns already finished stay in storage.
- R7: `singular` holds its value until the next accepted start, which clears it.
- R8: Load writes and start pulses that arrive while `busy` is high change neither the stored matrix nor the course of the run.
- R9: With `rd_diag`=1 the read port returns d at row `rd_row`. With `rd_diag`=0 it returns l_row,col below the diagonal, 0x00010000 on the diagonal and 0 above it. Any index of 9 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Load write enable (ignored while busy) |
| ld_row | input | 4 | Load row index |
| ld_col | input | 4 | Load column index |
| ld_data | input | 32 | Load value, Q16.16 |
| start | input | 1 | Begin factorization (ignored while busy) |
| busy | output | 1 | Factorization in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| singular | output | 1 | Last run stopped on a non-positive pivot |
| rd_diag | input | 1 | 1 selects D, 0 selects L |
| rd_row | input | 4 | Read row index |
| rd_col | input | 4 | Read column index (ignored for D) |
| rd_data | output | 32 | Read value, Q16.16 |

## Verification
The embedded assertions check every cycle that `done` is a single pulse that ends `busy`, and that `singular` only rises together with `done`. They also check that the divider is never restarted mid-quotient, that it stays active for as long as the sequencer waits on it, and that every division uses a stored positive pivot. The numerical results depend on many cycles of rounding, accumulation and division order. The exact run length in cycles, the point at which a singular run stops, and the claim that writes, starts and upper-triangle values are ignored can only be shown by the bench. It mirrors the stored matrix, recomputes the factorization in fixed point on each start, and predicts `busy`, `done` and `singular` for every cycle.

// File: rtl/ldlt_pkg.sv
// Shared definitions for the factorizer.
// Assumes: nothing beyond IEEE 1800-2017.
package ldlt_pkg;
    // Sequencer states: idle, accumulate inner product, wait for quotient.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/ldlt_qmul.sv
// Signed fixed-point multiplier with round-half-up back to the input format.
// Assumes: operands and result share W bits with FRAC fraction bits;
// overflow wraps to the low W bits of the rounded product.
module ldlt_qmul #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] ax, bx, full, biased;
    logic                 unused_bits;

    // Full-width product, add half an LSB, take the aligned slice.
    always_comb begin
        ax     = {{W{a[W-1]}}, a};
        bx     = {{W{b[W-1]}}, b};
        full   = ax * bx;
        biased = full + (PW'(1) <<< (FRAC - 1));
        p      = biased[FRAC +: W];
    end

    assign unused_bits = ^{biased[PW-1:FRAC+W], biased[FRAC-1:0]};
endmodule

// File: rtl/ldlt_divider.sv
// Sequential restoring divider producing a signed fixed-point quotient.
// One quotient bit per cycle, W iterations after the go cycle; valid pulses
// for one cycle when the quotient is ready. Magnitude saturates at 2^(W-1)-1.
// Assumes: den is non-zero; go is only raised while the divider is idle.
module ldlt_divider #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                running,
    output logic                valid,
    output logic signed [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);
    localparam logic [W-1:0] QMAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0]  mag_n, mag_d, dreg, rem, shf, q, qmag;
    logic [W:0]    trial, diff;
    logic          neg, ovf, ge;
    logic [CW-1:0] cnt;
    logic          unused_top;

    // Operand magnitudes and one restoring trial step.
    always_comb begin
        mag_n = num[W-1] ? W'(-num) : W'(num);
        mag_d = den[W-1] ? W'(-den) : W'(den);
        trial = {rem, shf[W-1]};
        diff  = trial - {1'b0, dreg};
        ge    = (trial >= {1'b0, dreg});
    end

    assign unused_top = diff[W];

    // Loads operands on go, then shifts one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreg  <= '0;
            rem   <= '0;
            shf   <= '0;
            q     <= '0;
            neg   <= 1'b0;
            ovf   <= 1'b0;
            cnt   <= '0;
            valid <= 1'b0;
        end else if (go) begin
            dreg  <= mag_d;
            rem   <= W'(mag_n[W-1:W-FRAC]);
            shf   <= {mag_n[W-FRAC-1:0], {FRAC{1'b0}}};
            q     <= '0;
            neg   <= num[W-1] ^ den[W-1];
            ovf   <= (W'(mag_n[W-1:W-FRAC]) >= mag_d);
            cnt   <= CW'(W);
            valid <= 1'b0;
        end else if (cnt != '0) begin
            rem   <= ge ? diff[W-1:0] : trial[W-1:0];
            shf   <= {shf[W-2:0], 1'b0};
            q     <= {q[W-2:0], ge};
            cnt   <= cnt - 1'b1;
            valid <= (cnt == CW'(1));
        end else begin
            valid <= 1'b0;
        end
    end

    // Saturate the magnitude, then apply the sign.
    always_comb begin
        qmag = (ovf || q[W-1]) ? QMAX : q;
        quot = neg ? -$signed(qmag) : $signed(qmag);
    end

    assign running = (cnt != '0);

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !running);                                   // R5
    AST_DIV_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(running));                          // R5
endmodule

// File: rtl/ldlt_store.sv
// Square matrix storage with one write port and NRD combinational read ports.
// Out-of-range indices read as zero and are not written.
// Assumes: at most one write per cycle.
module ldlt_store #(
    parameter int N   = 9,
    parameter int W   = 32,
    parameter int IW  = 4,
    parameter int NRD = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IW-1:0]             wrow,
    input  logic [IW-1:0]             wcol,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][IW-1:0]    rrow,
    input  logic [NRD-1:0][IW-1:0]    rcol,
    output logic [NRD-1:0][W-1:0]     rdata
);
    logic [W-1:0] mem [N][N];

    // Clears the array on reset, otherwise takes the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (we && (wrow < IW'(N)) && (wcol < IW'(N))) begin
            mem[wrow][wcol] <= wdata;
        end
    end

    // One bounded read mux per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if ((rrow[g] < IW'(N)) && (rcol[g] < IW'(N)))
                rdata[g] = mem[rrow[g]][rcol[g]];
            else
                rdata[g] = '0;
        end
    end
endmodule

// File: rtl/ldlt_factor.sv
// In-place B = L*D*L^T factorization of an N x N symmetric matrix, Q16.16.
// Column order: pivot first, then the rows below it, each inner product
// accumulated one rounded term per cycle and divided by the new pivot.
// Assumes: only the lower triangle of B is meaningful; loads and starts are
// accepted only while idle; results are valid after done.
module ldlt_factor #(
    parameter int N    = 9,
    parameter int W    = 32,
    parameter int FRAC = 16,
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [IW-1:0] ld_row,
    input  logic [IW-1:0] ld_col,
    input  logic [W-1:0]  ld_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          singular,
    input  logic          rd_diag,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [W-1:0]  rd_data
);
    import ldlt_pkg::*;

    localparam int NRD = 6;
    localparam logic [IW-1:0] LAST = IW'(N - 1);
    localparam logic [W-1:0]  ONE  = W'(1) << FRAC;

    eng_state_t           state;
    logic [IW-1:0]        i, j, k;
    logic signed [W-1:0]  acc, t1, term, value, div_quot;
    logic                 div_go, div_valid, div_running;
    logic                 eng_we, st_we;
    logic [IW-1:0]        st_row, st_col;
    logic [W-1:0]         st_data, eng_data;
    logic [NRD-1:0][IW-1:0] rrow, rcol;
    logic [NRD-1:0][W-1:0]  rdata;

    // Read ports: 0 external, 1 l_ik, 2 d_kk, 3 l_jk, 4 b_ij, 5 d_jj.
    assign rrow[0] = rd_row;
    assign rcol[0] = rd_diag ? rd_row : rd_col;
    assign rrow[1] = i;  assign rcol[1] = k;
    assign rrow[2] = k;  assign rcol[2] = k;
    assign rrow[3] = j;  assign rcol[3] = k;
    assign rrow[4] = i;  assign rcol[4] = j;
    assign rrow[5] = j;  assign rcol[5] = j;

    ldlt_store #(.N(N), .W(W), .IW(IW), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .wrow(st_row), .wcol(st_col),
        .wdata(st_data), .rrow(rrow), .rcol(rcol), .rdata(rdata)
    );

    ldlt_qmul #(.W(W), .FRAC(FRAC)) u_mul_a (
        .a($signed(rdata[1])), .b($signed(rdata[2])), .p(t1)
    );
    ldlt_qmul #(.W(W), .FRAC(FRAC)) u_mul_b (
        .a(t1), .b($signed(rdata[3])), .p(term)
    );

    ldlt_divider #(.W(W), .FRAC(FRAC)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(value),
        .den($signed(rdata[5])), .running(div_running),
        .valid(div_valid), .quot(div_quot)
    );

    // Residual of the current entry and the engine's write request.
    always_comb begin
        value    = $signed(rdata[4]) - acc;
        div_go   = (state == ST_ACC) && (k == j) && (i != j);
        eng_we   = ((state == ST_ACC) && (k == j) && (i == j) && (value > 0))
                || ((state == ST_DIV) && div_valid);
        eng_data = (state == ST_DIV) ? div_quot : value;
    end

    // Storage write mux: engine while running, load port while idle.
    always_comb begin
        st_we   = eng_we || (ld_we && !busy);
        st_row  = eng_we ? i : ld_row;
        st_col  = eng_we ? j : ld_col;
        st_data = eng_we ? eng_data : ld_data;
    end

    // Sequences columns, rows and inner-product terms; raises done/singular.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            i        <= '0;
            j        <= '0;
            k        <= '0;
            acc      <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            singular <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_ACC;
                        busy     <= 1'b1;
                        singular <= 1'b0;
                        i        <= '0;
                        j        <= '0;
                        k        <= '0;
                        acc      <= '0;
                    end
                end
                ST_ACC: begin
                    if (k != j) begin
                        acc <= acc + term;
                        k   <= k + 1'b1;
                    end else if (i == j) begin
                        if (value <= 0) begin
                            singular <= 1'b1;
                            done     <= 1'b1;
                            busy     <= 1'b0;
                            state    <= ST_IDLE;
                        end else if (j == LAST) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            i   <= j + 1'b1;
                            k   <= '0;
                            acc <= '0;
                        end
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        if (i == LAST) begin
                            j <= j + 1'b1;
                            i <= j + 1'b1;
                        end else begin
                            i <= i + 1'b1;
                        end
                        k     <= '0;
                        acc   <= '0;
                        state <= ST_ACC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // External view: D on request, implicit unit diagonal and zero upper L.
    always_comb begin
        if (rd_diag)
            rd_data = rdata[0];
        else if ((rd_row >= IW'(N)) || (rd_col >= IW'(N)))
            rd_data = '0;
        else if (rd_row == rd_col)
            rd_data = ONE;
        else if (rd_row < rd_col)
            rd_data = '0;
        else
            rd_data = rdata[0];
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                   // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                    // R3
    AST_SINGULAR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(singular) |-> done);                          // R6
    AST_DIVISOR_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIV) |-> ($signed(rdata[5]) > 0));     // R5
    AST_WAIT_ON_DIVIDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DIV) && !div_valid) |-> div_running); // R5
endmodule

// File: tb/sim_ldlt_factor.sv
module sim_ldlt_factor;
    localparam int N = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_row = '0, ld_col = '0;
    logic [31:0] ld_data = '0;
    logic        start = 1'b0;
    logic        busy, done, singular;
    logic        rd_diag = 1'b0;
    logic [3:0]  rd_row = '0, rd_col = '0;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    ldlt_factor u0 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_row(ld_row),
        .ld_col(ld_col), .ld_data(ld_data), .start(start), .busy(busy),
        .done(done), .singular(singular), .rd_diag(rd_diag),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    int  errors = 0, checks = 0, cyc = 0;
    int  sh [N][N];   // mirror of the stored matrix
    int  gm [N][N];   // matrix to load
    bit  m_busy, m_done, m_sing, exp_sing, finished;
    int  m_left, exp_cycles;

    function automatic int qmul(int a, int b);
        longint p = longint'(a) * longint'(b);
        p = (p + 64'sd32768) >>> 16;
        return int'(p);
    endfunction

    function automatic int qdiv(int n, int d);
        longint mn = (n < 0) ? -longint'(n) : longint'(n);
        longint md = (d < 0) ? -longint'(d) : longint'(d);
        longint q  = (mn <<< 16) / md;
        if (q > 64'sh7FFFFFFF) q = 64'sh7FFFFFFF;
        return ((n < 0) != (d < 0)) ? int'(-q) : int'(q);
    endfunction

    // Reference factorization on the mirror; also predicts cycles.
    function automatic void ref_run();
        int acc, val;
        exp_sing   = 1'b0;
        exp_cycles = 0;
        for (int j = 0; j < N; j++) begin
            acc = 0;
            for (int k = 0; k < j; k++) acc += qmul(qmul(sh[j][k], sh[k][k]), sh[j][k]);
            val = sh[j][j] - acc;
            exp_cycles += j + 1;
            if (val <= 0) begin
                exp_sing = 1'b1;
                return;
            end
            sh[j][j] = val;
            for (int i = j + 1; i < N; i++) begin
                acc = 0;
                for (int k = 0; k < j; k++) acc += qmul(qmul(sh[i][k], sh[k][k]), sh[j][k]);
                sh[i][j] = qdiv(sh[i][j] - acc, sh[j][j]);
                exp_cycles += j + 34;
            end
        end
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle reference of the control behaviour.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_sing = 0; m_left = 0;
            for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) sh[r][c] = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (ld_we && ld_row < N && ld_col < N) sh[ld_row][ld_col] = ld_data;
                if (start) begin
                    ref_run();
                    m_busy = 1; m_left = exp_cycles; m_sing = 0;
                end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_sing = exp_sing;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 busy", 32'(busy), 32'(m_busy));
            chk("R3 done", 32'(done), 32'(m_done));
            chk("R7 singular", 32'(singular), 32'(m_sing));
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic load_gm();
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                ld_we = 1; ld_row = 4'(r); ld_col = 4'(c); ld_data = gm[r][c];
            end
        end
        @(negedge clk);
        ld_we = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic readback(string tg);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                rd_diag = 0; rd_row = 4'(r); rd_col = 4'(c);
                #1;
                chk({tg, " R5 L"}, rd_data, (r > c) ? sh[r][c] : (r == c) ? 32'h10000 : 32'h0);
            end
            @(negedge clk);
            rd_diag = 1; rd_row = 4'(r); rd_col = 4'(0);
            #1;
            chk({tg, " R4 D"}, rd_data, sh[r][r]);
        end
        @(negedge clk);
        rd_diag = 0;
    endtask

    initial begin
        finished = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 singular", 32'(singular), 0);
        rd_diag = 1; rd_row = 4'd3; #1; chk("R1 D read", rd_data, 0);
        rd_diag = 0; rd_row = 4'd5; rd_col = 4'd2; #1; chk("R1 L read", rd_data, 0);
        rd_row = 4'd2; #1; chk("R1 L diag", rd_data, 32'h10000);

        // Diagonal matrix, then a second run on the stored result.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
            gm[r][c] = (r == c) ? (r + 2) * 65536 : 0;
        load_gm(); pulse_start(); wait_done();
        readback("diag");
        pulse_start(); wait_done();
        readback("rerun");

        // R2: dense SPD lower triangle, garbage above the diagonal.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
            gm[r][c] = (r == c) ? (20 + r) * 65536 :
                       (r > c)  ? ((r + 2 * c) % 5 - 2) * 32768 : 32'h7F000000;
        load_gm(); pulse_start(); wait_done();
        readback("R2 upper ignored");

        // R8: write and start while busy must be ignored.
        load_gm(); pulse_start();
        repeat (60) @(negedge clk);
        ld_we = 1; ld_row = 4'd8; ld_col = 4'd8; ld_data = 0; start = 1;
        @(negedge clk);
        ld_we = 1; ld_row = 4'd8; ld_col = 4'd0; ld_data = 32'h00050000; start = 0;
        @(negedge clk);
        ld_we = 0;
        wait_done();
        readback("R8 busy writes");

        // R6: zero pivot in column 4.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
            gm[r][c] = (r == c && r != 4) ? 65536 : 0;
        load_gm(); pulse_start(); wait_done();
        chk("R6 singular zero pivot", 32'(singular), 1);
        readback("R6 partial");

        // R6: negative first pivot.
        gm[4][4] = 65536; gm[0][0] = -65536;
        load_gm(); pulse_start(); wait_done();
        chk("R6 singular negative pivot", 32'(singular), 1);
        repeat (5) @(negedge clk);
        chk("R7 singular held", 32'(singular), 1);

        // R7: next good run clears singular.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++)
            gm[r][c] = (r == c) ? (4 + r) * 65536 :
                       (r > c)  ? ((r * 7 + c * 3) % 9 - 4) * 8192 : -1;
        load_gm(); pulse_start(); wait_done();
        chk("R7 singular cleared", 32'(singular), 0);
        readback("R7 recovery");

        // R9: out-of-range and above-diagonal reads.
        rd_diag = 0; rd_row = 4'd9;  rd_col = 4'd0; #1; chk("R9 row range", rd_data, 0);
        rd_row = 4'd3; rd_col = 4'd12; #1; chk("R9 col range", rd_data, 0);
        rd_row = 4'd1; rd_col = 4'd7;  #1; chk("R9 upper zero", rd_data, 0);
        rd_diag = 1; rd_row = 4'd15;  #1; chk("R9 D range", rd_data, 0);
        rd_diag = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule